// File: doc/BRIEF.md
# Iterative ARX-Box Unit

This unit applies a four-round add-rotate-XOR box to a 64-bit value held as two 32-bit words, x and y. A 32-bit constant c tweaks the box. A permutation core calls it once for each branch in each step. It presents the pair and the constant together with a one-cycle start strobe. The unit then computes one round per clock with a single adder. When the last round is done it raises a done flag and holds the result until the next accepted start.

In each round the unit does three things in order. First x gains y rotated right. Then y is XORed with the new x rotated right. Last, x is XORed with the constant. The two rotation amounts change from round to round on a fixed schedule. The constant stays the same in every round.

Top module: `arx_box_iter`

## Requirements
- R1: After reset, done is 0 and x_out and y_out are both 0.
- R2: Each round replaces x by (x + rotr(y, a)) mod 2^32. It then replaces y by y XOR rotr(x', b), where x' is the sum just formed. It then replaces x by x' XOR c.
- R3: The rotation pairs (a, b) for rounds 0, 1, 2 and 3 are (31,24), (17,17), (0,31) and (24,16). Rotation is to the right, toward bit 0.
- R4: The same constant c, as sampled with the start strobe, is applied in all four rounds.
- R5: A start that is accepted on clock edge E0 runs the rounds on edges E1 to E4. done is low after E1, E2 and E3, and done is high after E4, with x_out and y_out equal to the box result.
- R6: While done is high and start is low, done stays high and x_out and y_out do not change.
- R7: A start asserted while a computation is in progress is ignored. The running result is unchanged and done still rises after E4 of the original start.
- R8: A start asserted while the unit is idle or done is accepted. done is low on the following cycle and the new computation begins, with the round counter back at round 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin a box computation |
| x_in | input | 32 | First input word |
| y_in | input | 32 | Second input word |
| c_in | input | 32 | Round constant |
| x_out | output | 32 | First result word, valid while done is high |
| y_out | output | 32 | Second result word, valid while done is high |
| done | output | 1 | Result valid; held until the next accepted start |

## Verification
The assertions assume that start is a synchronous level sampled on the rising edge. They also assume that x_in, y_in and c_in matter only on the edge where a start is accepted. The bench drives every input on the falling edge. It changes the data inputs freely at other times, so that any late sampling of them shows up in the result. It injects starts with unrelated data in the middle of a run to exercise the busy case. It also leaves starts idle for several cycles after done, so the hold properties are exercised on their intended path.

// File: rtl/arx_pkg.sv
package arx_pkg;

   localparam int ARX_ROUNDS = 4;

   // additive rotation amount for each round
   function automatic int rot_add(input int r);
      case (r)
         0:       return 31;
         1:       return 17;
         2:       return 0;
         default: return 24;
      endcase
   endfunction

   // rotation applied to the fresh sum before it is folded into y
   function automatic int rot_mix(input int r);
      case (r)
         0:       return 24;
         1:       return 17;
         2:       return 31;
         default: return 16;
      endcase
   endfunction

endpackage

// File: rtl/arx_round.sv
module arx_round #(
   parameter int W      = 32,
   parameter int NR     = 4,
   parameter int IDX_W  = 2
) (
   input  logic [W-1:0]     x_i,
   input  logic [W-1:0]     y_i,
   input  logic [W-1:0]     c_i,
   input  logic [IDX_W-1:0] rnd_i,
   output logic [W-1:0]     x_o,
   output logic [W-1:0]     y_o
);

   logic [W-1:0] y_rot [NR];
   logic [W-1:0] s_rot [NR];
   logic [W-1:0] y_sel;
   logic [W-1:0] sum_w;
   logic [W-1:0] s_sel;

   // one rotated copy of y and of the sum per round; each is plain wiring
   for (genvar r = 0; r < NR; r++) begin : g_rot
      localparam int RA = arx_pkg::rot_add(r) % W;
      localparam int RB = arx_pkg::rot_mix(r) % W;
      if (RA == 0) begin : g_a_none
         assign y_rot[r] = y_i;
      end else begin : g_a_some
         assign y_rot[r] = {y_i[RA-1:0], y_i[W-1:RA]};
      end
      if (RB == 0) begin : g_b_none
         assign s_rot[r] = sum_w;
      end else begin : g_b_some
         assign s_rot[r] = {sum_w[RB-1:0], sum_w[W-1:RB]};
      end
   end

   always_comb begin
      y_sel = y_rot[0];
      s_sel = s_rot[0];
      for (int r = 1; r < NR; r++) begin
         if (rnd_i == IDX_W'(r)) begin
            y_sel = y_rot[r];
            s_sel = s_rot[r];
         end
      end
   end

   assign sum_w = x_i + y_sel;
   assign y_o   = y_i ^ s_sel;
   assign x_o   = sum_w ^ c_i;

endmodule

// File: rtl/arx_ctrl.sv
module arx_ctrl #(
   parameter int NR    = 4,
   parameter int IDX_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   output logic             load,
   output logic             step,
   output logic             busy,
   output logic             done,
   output logic [IDX_W-1:0] rnd
);

   localparam logic [IDX_W-1:0] LAST = IDX_W'(NR - 1);

   assign load = start && !busy;
   assign step = busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         done <= 1'b0;
         rnd  <= '0;
      end else if (load) begin
         busy <= 1'b1;
         done <= 1'b0;
         rnd  <= '0;
      end else if (busy) begin
         rnd <= rnd + 1'b1;
         if (rnd == LAST) begin
            busy <= 1'b0;
            done <= 1'b1;
         end
      end
   end

   // R5
   rnd_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && rnd != LAST |=> busy && rnd == IDX_W'($past(rnd) + 1'b1));

   // R5
   done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(busy) && $past(rnd) == LAST);

   // R5
   busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done));

   // R8
   restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start && !busy |=> busy && !done && rnd == '0);

endmodule

// File: rtl/arx_state.sv
module arx_state #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         step,
   input  logic         start,
   input  logic [W-1:0] x_ld,
   input  logic [W-1:0] y_ld,
   input  logic [W-1:0] c_ld,
   input  logic [W-1:0] x_nx,
   input  logic [W-1:0] y_nx,
   output logic [W-1:0] x_q,
   output logic [W-1:0] y_q,
   output logic [W-1:0] c_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         x_q <= '0;
         y_q <= '0;
         c_q <= '0;
      end else if (load) begin
         x_q <= x_ld;
         y_q <= y_ld;
         c_q <= c_ld;
      end else if (step) begin
         x_q <= x_nx;
         y_q <= y_nx;
      end
   end

   // R4, R7
   const_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step && start |=> c_q == $past(c_q));

endmodule

// File: rtl/arx_box_iter.sv
module arx_box_iter #(
   parameter int WORD_W     = 32,
   parameter int NUM_ROUNDS = arx_pkg::ARX_ROUNDS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [WORD_W-1:0] x_in,
   input  logic [WORD_W-1:0] y_in,
   input  logic [WORD_W-1:0] c_in,
   output logic [WORD_W-1:0] x_out,
   output logic [WORD_W-1:0] y_out,
   output logic              done
);

   localparam int IDX_W = (NUM_ROUNDS > 1) ? $clog2(NUM_ROUNDS) : 1;

   if (WORD_W != 32) begin : g_bad_width
      $error("arx_box_iter: rotation schedule is defined for 32-bit words");
   end
   if (NUM_ROUNDS != arx_pkg::ARX_ROUNDS) begin : g_bad_rounds
      $error("arx_box_iter: round count must match the rotation schedule");
   end

   logic              load, step, busy;
   logic [IDX_W-1:0]  rnd;
   logic [WORD_W-1:0] x_q, y_q, c_q, x_nx, y_nx;

   arx_ctrl #(.NR(NUM_ROUNDS), .IDX_W(IDX_W)) ctrl_i (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .load  (load),
      .step  (step),
      .busy  (busy),
      .done  (done),
      .rnd   (rnd)
   );

   arx_state #(.W(WORD_W)) state_i (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load),
      .step  (step),
      .start (start),
      .x_ld  (x_in),
      .y_ld  (y_in),
      .c_ld  (c_in),
      .x_nx  (x_nx),
      .y_nx  (y_nx),
      .x_q   (x_q),
      .y_q   (y_q),
      .c_q   (c_q)
   );

   arx_round #(.W(WORD_W), .NR(NUM_ROUNDS), .IDX_W(IDX_W)) round_i (
      .x_i   (x_q),
      .y_i   (y_q),
      .c_i   (c_q),
      .rnd_i (rnd),
      .x_o   (x_nx),
      .y_o   (y_nx)
   );

   assign x_out = x_q;
   assign y_out = y_q;

   // R6
   done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done && !start |=> done && $stable(x_out) && $stable(y_out));

endmodule

// File: tb/arx_box_iter_tb.sv
module arx_box_iter_tb_top;

   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] x_in = '0, y_in = '0, c_in = '0;
   logic [31:0] x_out, y_out;
   logic        done;

   int n_chk = 0;
   int n_err = 0;
   int cyc   = 0;

   always #(CLK_P/2) clk = ~clk;

   arx_box_iter dut_i (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .x_in  (x_in),
      .y_in  (y_in),
      .c_in  (c_in),
      .x_out (x_out),
      .y_out (y_out),
      .done  (done)
   );

   function automatic logic [31:0] ror(input logic [31:0] v, input int n);
      if (n == 0) return v;
      return (v >> n) | (v << (32 - n));
   endfunction

   function automatic logic [63:0] ref_box(input logic [31:0] x, input logic [31:0] y,
                                           input logic [31:0] c);
      x = x + ror(y, 31); y = y ^ ror(x, 24); x = x ^ c;
      x = x + ror(y, 17); y = y ^ ror(x, 17); x = x ^ c;
      x = x + y;          y = y ^ ror(x, 31); x = x ^ c;
      x = x + ror(y, 24); y = y ^ ror(x, 16); x = x ^ c;
      return {x, y};
   endfunction

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         finish_run();
      end
   end

   // one computation; optional start with unrelated data in the middle (R7)
   task automatic run_box(input logic [31:0] x, input logic [31:0] y,
                          input logic [31:0] c, input bit poke, input string req);
      logic [63:0] exp = ref_box(x, y, c);
      @(negedge clk);
      start = 1'b1; x_in = x; y_in = y; c_in = c;
      @(negedge clk);                 // E0 has passed
      start = 1'b0; x_in = ~x; y_in = y ^ 32'h5A5A_A5A5; c_in = c + 32'd7;
      for (int k = 1; k <= 4; k++) begin
         @(negedge clk);              // Ek has passed
         if (poke && k == 1) begin
            start = 1'b1; x_in = 32'h1234_5678; y_in = 32'h9ABC_DEF0; c_in = 32'hFFFF_0000;
         end
         if (k == 2) start = 1'b0;
         if (k < 4) check(done == 1'b0, "R5 done low before last round", {63'd0, done}, 64'd0);
      end
      check(done == 1'b1, "R5 done after fourth round", {63'd0, done}, 64'd1);
      check({x_out, y_out} == exp, req, {x_out, y_out}, exp);
   endtask

   initial begin
      logic [31:0] lf = 32'hACE1_2468;
      logic [63:0] held;
      repeat (3) @(negedge clk);
      check(done == 1'b0 && x_out == 0 && y_out == 0, "R1 reset state",
            {x_out, y_out}, 64'd0);
      rst_n = 1'b1;

      run_box(32'h0, 32'h0, 32'h0, 1'b0, "R2 all-zero input");
      run_box(32'h0, 32'h0000_0001, 32'h0, 1'b0, "R3 single y bit rotations");
      run_box(32'h8000_0000, 32'h0, 32'h0, 1'b0, "R3 single x bit rotations");
      run_box(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 1'b0, "R2 carry chain");
      run_box(32'h0, 32'h0, 32'hB7E1_5162, 1'b0, "R4 constant only");
      run_box(32'h0123_4567, 32'h89AB_CDEF, 32'hFFFF_FFFF, 1'b0, "R4 constant all ones");

      for (int b = 0; b < 32; b++)
         run_box(32'h1 << b, 32'h8000_0000 >> b, 32'h0, 1'b0, "R3 walking bits");
      for (int b = 0; b < 32; b++)
         run_box(32'h0, 32'h0, 32'h1 << b, 1'b0, "R4 walking constant bit");

      for (int i = 0; i < 150; i++) begin
         logic [31:0] a, bb, cc;
         lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]}; a  = lf * 32'h9E37_79B9;
         lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]}; bb = lf ^ a;
         lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]}; cc = lf + bb;
         run_box(a, bb, cc, (i % 5) == 0, (i % 5) == 0 ? "R7 start while busy ignored"
                                                         : "R2 pseudo-random vector");
      end

      // R6: hold with start low and inputs wiggling
      held = {x_out, y_out};
      for (int k = 0; k < 4; k++) begin
         x_in = x_in + 32'd3; y_in = ~y_in; c_in = c_in ^ 32'hF0F0_F0F0;
         @(negedge clk);
         check(done == 1'b1 && {x_out, y_out} == held, "R6 result held",
               {x_out, y_out}, held);
      end

      // R8: restart from done clears done next cycle
      start = 1'b1; x_in = 32'hDEAD_BEEF; y_in = 32'h0BAD_F00D; c_in = 32'h3;
      @(negedge clk);
      start = 1'b0;
      check(done == 1'b0, "R8 restart clears done", {63'd0, done}, 64'd0);
      check({x_out, y_out} == {32'hDEAD_BEEF, 32'h0BAD_F00D}, "R8 new operands loaded",
            {x_out, y_out}, {32'hDEAD_BEEF, 32'h0BAD_F00D});
      repeat (4) @(negedge clk);
      check({x_out, y_out} == ref_box(32'hDEAD_BEEF, 32'h0BAD_F00D, 32'h3),
            "R8 restarted result", {x_out, y_out},
            ref_box(32'hDEAD_BEEF, 32'h0BAD_F00D, 32'h3));

      finish_run();
   end

endmodule